// File: doc/BRIEF.md
# Serial ADC output sequencer

This block is the digital half of a sampling 12-bit converter that reports its result over a serial line. A host selects it with an active-low select, supplies a serial clock and reads 16 bits per conversion. The sample word arrives on a parallel input and is captured when a conversion begins. The block drives a serial data bit with a separate output enable for a tri-state pad, and a busy flag that is high while a frame is being shifted.

All three control inputs are oversampled on the system clock through synchronizers. The select and shutdown inputs also gate the outputs combinationally, so the pad is released without waiting for a clock. In slave use the host raises the select between conversions. In free-running use the select stays low and frames repeat, one idle serial clock apart. After shutdown is released, a guard interval counted in system clocks must pass before a start is accepted. A start that comes too early is refused and raises an error flag.

Top module: `adc_serial_seq`

## Requirements
- R1: While `cs_ni` is high, `dout_oe_o` and `status_o` are low at once, and the sequencer returns to idle within SYNC_STAGES+1 system clocks. A later falling edge of `cs_ni` starts a fresh frame from its first bit.
- R2: A falling edge of `cs_ni` captures `sample_i` and starts a frame (`status_o` high), provided shutdown is low and the guard interval has expired.
- R3: A frame is 16 bits. Bits 1 to 4 are zero, and bits 5 to 16 carry the captured sample with the most significant bit first.
- R4: The first bit is on `dout_o` before the first rising edge of `sclk_i`. `dout_o` advances only after a falling edge of `sclk_i` and holds its value across the rising edge.
- R5: The captured sample stays fixed for the whole frame, whatever `sample_i` does meanwhile.
- R6: With `cs_ni` held low, the falling edge that ends bit 16 is followed by exactly one dead serial clock cycle. In that cycle `status_o` is low and `dout_o` is 0. The next falling edge captures `sample_i` again and starts the next frame.
- R7: `status_o` is high only while a frame shifts. It is low in idle, in the dead cycle, and whenever `cs_ni` or `shdn_i` is high.
- R8: A high `shdn_i` drops `dout_oe_o` and `status_o` at once and aborts the frame. Releasing it does not resume the frame; only a new falling edge of `cs_ni` starts one.
- R9: For GUARD_CYC system clocks after `shdn_i` is released, a falling edge of `cs_ni` is refused. No frame starts and `early_err_o` goes high. The flag stays high until a start is accepted.
- R10: `dout_oe_o` is high only while `cs_ni` is low, `shdn_i` is low and a frame or dead cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for oversampling |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low select; its falling edge starts a conversion |
| sclk_i | input | 1 | Serial clock from the host |
| shdn_i | input | 1 | Shutdown; high aborts and powers down |
| sample_i | input | 12 | Parallel sample word |
| dout_o | output | 1 | Serial data bit |
| dout_oe_o | output | 1 | Output enable for the data pad |
| status_o | output | 1 | High while a conversion frame shifts |
| early_err_o | output | 1 | Start refused during guard interval |

## Verification
Shutdown can rise in the same instant as a serial clock falling edge, so an abort and a bit advance compete for the same clock. The bench lowers `sclk_i` and raises `shdn_i` in one time step in the middle of a frame. It requires the outputs to drop at once and no frame to resume after release. It also places a select falling edge inside the guard interval and checks that the refusal takes precedence over the start.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_DEAD  = 2'd2,
    ST_BLOCK = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int unsigned W           = 3,
  parameter int unsigned STAGES      = 2,
  parameter logic [W-1:0] RST_VAL    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/adc_guard.sv
module adc_guard #(
  parameter int unsigned GUARD_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shdn_i,
  output logic busy_o
);
  localparam int unsigned GW = $clog2(GUARD_CYC + 1);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (shdn_i)        cnt_q <= GW'(GUARD_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned LEAD_ZEROS = 4,
  localparam int unsigned FRAME_W   = DATA_W + LEAD_ZEROS,
  localparam int unsigned IDX_W     = $clog2(FRAME_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic              guard_i,
  input  logic [DATA_W-1:0] sample_i,
  output seq_state_e        state_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              msb_o,
  output logic [DATA_W-1:0] held_o,
  output logic              err_o
);
  seq_state_e         state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] shift_q;
  logic [DATA_W-1:0]  held_q;
  logic               err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shift_q <= '0;
      held_q  <= '0;
      err_q   <= 1'b0;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shift_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (guard_i) begin
              err_q   <= 1'b1;
              state_q <= ST_BLOCK;
            end else begin
              err_q   <= 1'b0;
              held_q  <= sample_i;
              shift_q <= {{LEAD_ZEROS{1'b0}}, sample_i};
              idx_q   <= '0;
              state_q <= ST_CONV;
            end
          end
        end
        ST_CONV: begin
          if (adv_i) begin
            if (idx_q == IDX_W'(FRAME_W - 1)) begin
              shift_q <= '0;
              state_q <= ST_DEAD;
            end else begin
              shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
              idx_q   <= idx_q + 1'b1;
            end
          end
        end
        ST_DEAD: begin
          if (adv_i) begin
            held_q  <= sample_i;
            shift_q <= {{LEAD_ZEROS{1'b0}}, sample_i};
            idx_q   <= '0;
            state_q <= ST_CONV;
          end
        end
        default: ;  // ST_BLOCK: wait for deselect
      endcase
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign msb_o   = shift_q[FRAME_W-1];
  assign held_o  = held_q;
  assign err_o   = err_q;
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned LEAD_ZEROS  = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GUARD_CYC   = 2000,
  localparam int unsigned FRAME_W    = DATA_W + LEAD_ZEROS,
  localparam int unsigned IDX_W      = $clog2(FRAME_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              shdn_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              status_o,
  output logic              early_err_o
);
  // bit 2: cs, bit 1: sclk, bit 0: shdn
  logic [2:0] raw, syn;
  logic       cs_s, sclk_s, shdn_s;
  logic       cs_prev_q, sclk_prev_q;
  logic       cs_fall, sclk_fall, guard_busy, live;
  seq_state_e state_q;
  logic [IDX_W-1:0]  bit_idx;
  logic              shift_msb;
  logic [DATA_W-1:0] sample_q;

  assign raw = {cs_ni, sclk_i, shdn_i};

  adc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );
  assign {cs_s, sclk_s, shdn_s} = syn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= cs_s;
      sclk_prev_q <= sclk_s;
    end
  end
  assign cs_fall   = cs_prev_q & ~cs_s;
  assign sclk_fall = sclk_prev_q & ~sclk_s;

  adc_guard #(.GUARD_CYC(GUARD_CYC)) i_guard (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .shdn_i(shdn_s),
    .busy_o(guard_busy)
  );

  adc_frame_ctrl #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (cs_s | shdn_s),
    .start_i (cs_fall),
    .adv_i   (sclk_fall),
    .guard_i (guard_busy),
    .sample_i(sample_i),
    .state_o (state_q),
    .idx_o   (bit_idx),
    .msb_o   (shift_msb),
    .held_o  (sample_q),
    .err_o   (early_err_o)
  );

  // raw pins gate the outputs so release does not wait for a clock
  assign live      = ~cs_ni & ~shdn_i;
  assign dout_oe_o = live & ((state_q == ST_CONV) | (state_q == ST_DEAD));
  assign dout_o    = dout_oe_o & shift_msb;
  assign status_o  = live & (state_q == ST_CONV);
endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned LEAD_ZEROS = 4,
  localparam int unsigned FRAME_W   = DATA_W + LEAD_ZEROS,
  localparam int unsigned IDX_W     = $clog2(FRAME_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_s,
  input logic              shdn_s,
  input logic              cs_fall,
  input logic              sclk_fall,
  input logic              guard_busy,
  input seq_state_e        state_q,
  input logic [IDX_W-1:0]  bit_idx,
  input logic              shift_msb,
  input logic [DATA_W-1:0] sample_q,
  input logic              early_err_o
);
  p_cs_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> state_q == ST_IDLE);

  p_lead_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && bit_idx < IDX_W'(LEAD_ZEROS)) |-> !shift_msb);

  p_no_edge_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && $past(state_q == ST_CONV) && !$past(sclk_fall)
     && !$past(cs_s) && !$past(shdn_s)) |-> ($stable(shift_msb) && $stable(bit_idx)));

  p_sample_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && $past(state_q == ST_CONV)) |-> $stable(sample_q));

  p_dead_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEAD && $past(state_q == ST_CONV)) |-> $past(bit_idx) == IDX_W'(FRAME_W - 1));

  p_shdn_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_s |=> state_q == ST_IDLE);

  p_guard_refuse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && cs_fall && guard_busy && !shdn_s) |=> (state_q == ST_BLOCK && early_err_o));
endmodule

bind adc_serial_seq adc_serial_seq_chk #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_s       (cs_s),
  .shdn_s     (shdn_s),
  .cs_fall    (cs_fall),
  .sclk_fall  (sclk_fall),
  .guard_busy (guard_busy),
  .state_q    (state_q),
  .bit_idx    (bit_idx),
  .shift_msb  (shift_msb),
  .sample_q   (sample_q),
  .early_err_o(early_err_o)
);

// File: tb/test_adc_serial_seq.sv
module test_adc_serial_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8 * CLK_PERIOD;
  localparam int GUARD      = 64;

  logic clk_i = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sclk_i = 1'b0, shdn_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic dout_o, dout_oe_o, status_o, early_err_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  adc_serial_seq #(.GUARD_CYC(GUARD)) i_adc_serial_seq (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .shdn_i, .sample_i,
    .dout_o, .dout_oe_o, .status_o, .early_err_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  function automatic logic exp_bit(logic [11:0] s, int k);
    return (k < 4) ? 1'b0 : s[11-(k-4)];
  endfunction

  // one serial clock: sample before rise, again during high, then fall
  task automatic bit_cycle(logic [11:0] s, int k, bit chk);
    #HALF;
    if (chk) begin
      check("R3 bit before rise", dout_o, exp_bit(s, k));
      check("R7 status in frame", status_o, 1'b1);
    end
    sclk_i = 1'b1;
    #HALF;
    if (chk) check("R4 stable over rise", dout_o, exp_bit(s, k));
    sclk_i = 1'b0;
  endtask

  task automatic read_frame(logic [11:0] s, logic [11:0] later);
    for (int k = 0; k < 16; k++) begin
      bit_cycle(s, k, 1'b1);
      if (k == 7) sample_i = later;  // R5: changes must not leak
    end
  endtask

  task automatic t_reset;
    clks(3);
    check("R10 oe idle", dout_oe_o, 1'b0);
    check("R7 status idle", status_o, 1'b0);
    check("R9 err reset", early_err_o, 1'b0);
  endtask

  task automatic t_slave(logic [11:0] s);
    sample_i = s;
    cs_ni = 1'b0;
    clks(1);
    read_frame(s, ~s);
    cs_ni = 1'b1;
    #1;
    check("R1 oe off on deselect", dout_oe_o, 1'b0);
    check("R7 status off on deselect", status_o, 1'b0);
    clks(6);
  endtask

  task automatic t_cs_abort;
    sample_i = 12'h3C5;
    cs_ni = 1'b0;
    clks(1);
    for (int k = 0; k < 9; k++) bit_cycle(12'h3C5, k, 1'b1);
    cs_ni = 1'b1;
    #1;
    check("R1 oe drops at once", dout_oe_o, 1'b0);
    clks(6);
    t_slave(12'h5A6);  // R1: restart begins at bit 1
  endtask

  task automatic t_free_run;
    sample_i = 12'h9E1;
    cs_ni = 1'b0;
    clks(1);
    read_frame(12'h9E1, 12'h247);
    // dead cycle (R6)
    #HALF;
    check("R6 dead status low", status_o, 1'b0);
    check("R6 dead dout zero", dout_o, 1'b0);
    check("R10 oe kept in dead", dout_oe_o, 1'b1);
    sclk_i = 1'b1;
    #HALF;
    check("R6 dead status low high phase", status_o, 1'b0);
    sclk_i = 1'b0;
    read_frame(12'h247, 12'h800);
    bit_cycle(12'h0, 0, 1'b0);
    read_frame(12'h800, 12'h000);
    cs_ni = 1'b1;
    clks(6);
  endtask

  task automatic t_shdn_race;
    sample_i = 12'hFFF;
    cs_ni = 1'b0;
    clks(1);
    for (int k = 0; k < 6; k++) bit_cycle(12'hFFF, k, 1'b1);
    #HALF;
    sclk_i = 1'b1;
    #HALF;
    sclk_i = 1'b0;  // falling edge and shutdown together
    shdn_i = 1'b1;
    #1;
    check("R8 oe drops on shutdown", dout_oe_o, 1'b0);
    check("R8 status drops on shutdown", status_o, 1'b0);
    clks(10);
    shdn_i = 1'b0;
    clks(10);
    check("R8 no resume status", status_o, 1'b0);
    check("R8 no resume oe", dout_oe_o, 1'b0);
    cs_ni = 1'b1;
    clks(GUARD + 10);
  endtask

  task automatic t_guard;
    shdn_i = 1'b1;
    clks(5);
    shdn_i = 1'b0;
    clks(2);
    cs_ni = 1'b0;
    clks(10);
    check("R9 early err", early_err_o, 1'b1);
    check("R9 refused status", status_o, 1'b0);
    check("R9 refused oe", dout_oe_o, 1'b0);
    cs_ni = 1'b1;
    clks(GUARD + 10);
    check("R9 err sticky", early_err_o, 1'b1);
    sample_i = 12'h001;
    cs_ni = 1'b0;
    clks(6);
    check("R2 start after guard", status_o, 1'b1);
    check("R9 err cleared by start", early_err_o, 1'b0);
    read_frame(12'h001, 12'hABC);
    cs_ni = 1'b1;
    clks(6);
  endtask

  initial begin
    clks(4);
    rst_ni = 1'b1;
    t_reset();
    t_slave(12'hA5C);
    t_slave(12'hFFF);
    t_cs_abort();
    t_free_run();
    t_shdn_race();
    t_guard();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule